// File: doc/BRIEF.md
# Ethernet PHY Address Locator

This block works out at which management address an Ethernet PHY answers. A start pulse launches the search. When a preferred address is enabled, that address is probed first. If the probe fails, or no preferred address is enabled, the block walks the whole address space from the top address down. It stops at the first address whose status word shows the required capabilities.

Every probe is one read of PHY register 1, the status word. The read goes through a request/acknowledge port to an MDIO master, and only one read is outstanding at a time. A reply passes when it is not all ones and carries every bit of the capability mask 0x1808. Those bits are 10 Mb/s full duplex (bit 12), 10 Mb/s half duplex (bit 11) and auto-negotiation ability (bit 3).

At the end of the search the block pulses `done` and holds one of two results until the next start:
- `found`, with the address of the PHY that passed.
- `not_found`, with address 0.

Top module: `phy_locator`

## Requirements
- R1: After reset, `busy`, `done`, `found`, `not_found` and `rd_req` are 0 and `phy_addr` is 0.
- R2: On the cycle after a `start` pulse taken while idle, `rd_req` rises with `rd_reg` = 1. `rd_phy` equals `preset_addr` when `preset_en` was 1 at the start, and 31 otherwise.
- R3: While `rd_req` is high and no `rd_ack` has arrived, `rd_req` stays high and `rd_phy` stays unchanged. In the cycle after an acknowledged read, `rd_req` is low.
- R4: A reply of 0xFFFF never passes, even though it contains every mask bit.
- R5: A reply passes only if bits 12, 11 and 3 are all set. Any other bits are ignored.
- R6: If the preset probe passes, the search ends after that single read, with `found` = 1 and `phy_addr` = preset.
- R7: If the preset probe fails, the next reads go to 31, 30, 29 and so on, descending by one. The preset address is not skipped.
- R8: The scan stops at the first passing address, so the highest passing address is reported and no further reads are issued.
- R9: If no scanned address passes, the search ends after address 0 with `not_found` = 1 and `phy_addr` = 0. This takes 32 scan reads, plus the preset read if one was made.
- R10: `done` is a single-cycle pulse at the end of every search. `found` and `not_found` are never both high, and they hold until the next accepted start, which clears them.
- R11: A `start` pulse while `busy` is high has no effect on the read sequence or on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a search (ignored while busy) |
| preset_en | input | 1 | Probe `preset_addr` first |
| preset_addr | input | 5 | Preferred PHY address |
| rd_req | output | 1 | Read request to MDIO master, held until acknowledged |
| rd_phy | output | 5 | PHY address of the read |
| rd_reg | output | 5 | Register number of the read (always 1) |
| rd_ack | input | 1 | One-cycle acknowledge carrying read data |
| rd_data | input | 16 | Read data, valid with `rd_ack` |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle end-of-search pulse |
| found | output | 1 | A PHY passed the check |
| not_found | output | 1 | No PHY passed |
| phy_addr | output | 5 | Discovered address, 0 when none |

## Verification
A wrong address counter shows up on `rd_phy` at the very next read request. Examples are a scan that starts at the wrong end, one that skips after a failed preset, or one that steps by the wrong amount. An order monitor therefore flags it within one read of the fault. A faulty reply qualifier shows up at `done` as a wrong `found` or `phy_addr`, or as a different number of reads, because accepting or rejecting one reply changes where the scan stops. A broken end condition shows up as a read count that differs from the computed one, or as a missing or repeated `done` pulse.

// File: rtl/phy_locator_pkg.sv
// Shared types and defaults for the PHY address locator.
// Assumes a 5-bit management address space and 16-bit register data.
package phy_locator_pkg;
    localparam int unsigned ADDR_W_DEF = 5;
    localparam int unsigned DATA_W_DEF = 16;
    localparam logic [4:0] STATUS_REG_DEF = 5'd1;
    localparam logic [15:0] CAP_MASK_DEF = 16'h1808;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_READ = 2'd1,
        ST_GAP  = 2'd2
    } loc_state_t;
endpackage

// File: rtl/phy_reply_qual.sv
// Reply qualifier: decides whether a status word identifies a usable PHY.
// A word passes when it is not all ones and carries every bit of CAP_MASK.
// Purely combinational; assumes the caller samples it only with a valid reply.
module phy_reply_qual #(
    parameter int unsigned DATA_W = 16,
    parameter logic [DATA_W-1:0] CAP_MASK = 16'h1808
) (
    input  logic [DATA_W-1:0] reply,
    output logic              pass
);
    localparam logic [DATA_W-1:0] ALL_ONES = '1;

    // Reject an absent device, then require every capability bit.
    always_comb begin
        pass = (reply != ALL_ONES) && ((reply & CAP_MASK) == CAP_MASK);
    end
endmodule

// File: rtl/phy_locator_seq.sv
// Search sequencer: probes the preset address (optional), then scans
// from the top address downward, one read at a time, and records the result.
// Assumes rd_ack is a single-cycle pulse that only arrives while rd_req is high.
module phy_locator_seq
    import phy_locator_pkg::*;
#(
    parameter int unsigned ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              preset_en,
    input  logic [ADDR_W-1:0] preset_addr,
    input  logic              rd_ack,
    input  logic              reply_pass,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_phy,
    output logic              busy,
    output logic              done,
    output logic              found,
    output logic              not_found,
    output logic [ADDR_W-1:0] phy_addr
);
    localparam logic [ADDR_W-1:0] TOP_ADDR = '1;
    localparam logic [ADDR_W-1:0] LOW_ADDR = '0;

    loc_state_t        state;
    logic [ADDR_W-1:0] cur_addr;
    logic              on_preset;
    logic              found_q;
    logic              nf_q;
    logic              done_q;
    logic [ADDR_W-1:0] addr_q;

    // Main search state machine and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            cur_addr  <= LOW_ADDR;
            on_preset <= 1'b0;
            found_q   <= 1'b0;
            nf_q      <= 1'b0;
            done_q    <= 1'b0;
            addr_q    <= LOW_ADDR;
        end else begin
            done_q <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        state     <= ST_READ;
                        cur_addr  <= preset_en ? preset_addr : TOP_ADDR;
                        on_preset <= preset_en;
                        found_q   <= 1'b0;
                        nf_q      <= 1'b0;
                        addr_q    <= LOW_ADDR;
                    end
                end
                ST_READ: begin
                    if (rd_ack) begin
                        if (reply_pass) begin
                            found_q <= 1'b1;
                            addr_q  <= cur_addr;
                            done_q  <= 1'b1;
                            state   <= ST_IDLE;
                        end else if (on_preset) begin
                            on_preset <= 1'b0;
                            cur_addr  <= TOP_ADDR;
                            state     <= ST_GAP;
                        end else if (cur_addr == LOW_ADDR) begin
                            nf_q   <= 1'b1;
                            addr_q <= LOW_ADDR;
                            done_q <= 1'b1;
                            state  <= ST_IDLE;
                        end else begin
                            cur_addr <= cur_addr - 1'b1;
                            state    <= ST_GAP;
                        end
                    end
                end
                ST_GAP: begin
                    state <= ST_READ;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Output decode from registered state.
    always_comb begin
        rd_req    = (state == ST_READ);
        rd_phy    = cur_addr;
        busy      = (state != ST_IDLE);
        done      = done_q;
        found     = found_q;
        not_found = nf_q;
        phy_addr  = addr_q;
    end
endmodule

// File: rtl/phy_locator.sv
// Top of the PHY address locator: joins the reply qualifier to the
// search sequencer and drives a fixed register number on the read port.
// Assumes a read master that acknowledges each request exactly once.
module phy_locator
    import phy_locator_pkg::*;
#(
    parameter int unsigned       ADDR_W     = ADDR_W_DEF,
    parameter int unsigned       DATA_W     = DATA_W_DEF,
    parameter logic [4:0]        STATUS_REG = STATUS_REG_DEF,
    parameter logic [DATA_W-1:0] CAP_MASK   = CAP_MASK_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              preset_en,
    input  logic [ADDR_W-1:0] preset_addr,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_phy,
    output logic [4:0]        rd_reg,
    input  logic              rd_ack,
    input  logic [DATA_W-1:0] rd_data,
    output logic              busy,
    output logic              done,
    output logic              found,
    output logic              not_found,
    output logic [ADDR_W-1:0] phy_addr
);
    logic reply_pass;

    // Every probe targets the status register.
    always_comb rd_reg = STATUS_REG;

    phy_reply_qual #(
        .DATA_W   (DATA_W),
        .CAP_MASK (CAP_MASK)
    ) u_qual (
        .reply (rd_data),
        .pass  (reply_pass)
    );

    phy_locator_seq #(
        .ADDR_W (ADDR_W)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .preset_en   (preset_en),
        .preset_addr (preset_addr),
        .rd_ack      (rd_ack),
        .reply_pass  (reply_pass),
        .rd_req      (rd_req),
        .rd_phy      (rd_phy),
        .busy        (busy),
        .done        (done),
        .found       (found),
        .not_found   (not_found),
        .phy_addr    (phy_addr)
    );
endmodule

// File: rtl/phy_locator_chk.sv
// Property checker for the PHY address locator, bound to the top module.
// Watches only the top-level ports.
module phy_locator_chk #(
    parameter int unsigned       ADDR_W     = 5,
    parameter int unsigned       DATA_W     = 16,
    parameter logic [4:0]        STATUS_REG = 5'd1,
    parameter logic [DATA_W-1:0] CAP_MASK   = 16'h1808
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_req,
    input logic [ADDR_W-1:0] rd_phy,
    input logic [4:0]        rd_reg,
    input logic              rd_ack,
    input logic [DATA_W-1:0] rd_data,
    input logic              done,
    input logic              found,
    input logic              not_found,
    input logic [ADDR_W-1:0] phy_addr
);
    localparam logic [DATA_W-1:0] ALL_ONES = '1;

    // R2: every probe addresses the status register.
    a_r2_status_reg: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> rd_reg == STATUS_REG);

    // R3: an unacknowledged request is held with a stable address.
    a_r3_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_ack) |=> (rd_req && $stable(rd_phy)));

    // R3: request drops after each acknowledged read.
    a_r3_req_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && rd_ack) |=> !rd_req);

    // R4, R5: a rising found follows an acknowledged, qualifying reply.
    a_r5_found_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(found) |-> ($past(rd_ack) && ($past(rd_data) != ALL_ONES)
                          && (($past(rd_data) & CAP_MASK) == CAP_MASK)));

    // R9: a missing PHY reports address 0.
    a_r9_nf_addr: assert property (@(posedge clk) disable iff (!rst_n)
        not_found |-> phy_addr == '0);

    // R10: done lasts a single cycle.
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10: the two result flags exclude each other.
    a_r10_flags_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(found && not_found));

    // R10: done comes with exactly one result and no open request.
    a_r10_done_result: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($countones({found, not_found}) == 1 && !rd_req));
endmodule

bind phy_locator phy_locator_chk #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .STATUS_REG (STATUS_REG),
    .CAP_MASK   (CAP_MASK)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_req    (rd_req),
    .rd_phy    (rd_phy),
    .rd_reg    (rd_reg),
    .rd_ack    (rd_ack),
    .rd_data   (rd_data),
    .done      (done),
    .found     (found),
    .not_found (not_found),
    .phy_addr  (phy_addr)
);

// File: tb/phy_locator_bench.sv
// Bench for the PHY address locator: a table of scenarios walked by one loop,
// then directed tests for reset, reply qualification, busy starts and holding.
module phy_locator_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        preset_en = 1'b0;
    logic [4:0]  preset_addr = '0;
    logic        rd_req;
    logic [4:0]  rd_phy;
    logic [4:0]  rd_reg;
    logic        rd_ack = 1'b0;
    logic [15:0] rd_data = '0;
    logic        busy, done, found, not_found;
    logic [4:0]  phy_addr;

    int tests = 0;
    int fails = 0;
    int reads = 0;
    int dones = 0;
    int seq_err = 0;
    int lat = 0;
    int cycles = 0;
    logic [4:0]  exp_next = '0;
    logic        exp_pre = 1'b0;
    logic [15:0] replies [32];

    always #5 clk = ~clk;

    phy_locator u_phy_locator (
        .clk(clk), .rst_n(rst_n), .start(start),
        .preset_en(preset_en), .preset_addr(preset_addr),
        .rd_req(rd_req), .rd_phy(rd_phy), .rd_reg(rd_reg),
        .rd_ack(rd_ack), .rd_data(rd_data),
        .busy(busy), .done(done), .found(found),
        .not_found(not_found), .phy_addr(phy_addr)
    );

    // Responder: acknowledges each request two cycles after it is seen.
    always @(posedge clk) begin
        if (rd_ack) begin
            rd_ack <= 1'b0;
            lat    <= 0;
        end else if (rd_req) begin
            if (lat == 2) begin
                rd_ack  <= 1'b1;
                rd_data <= replies[rd_phy];
            end else begin
                lat <= lat + 1;
            end
        end else begin
            lat <= 0;
        end
    end

    // Monitor: counts reads and done pulses; checks read order (R2, R7).
    always @(negedge clk) begin
        cycles <= cycles + 1;
        if (done) dones <= dones + 1;
        if (rd_req && rd_ack) begin
            reads <= reads + 1;
            if (rd_phy != exp_next || rd_reg != 5'd1) begin
                seq_err <= seq_err + 1;
                $display("[TB] FAIL R7 read order: got phy %0d reg %0d, expected phy %0d reg 1",
                         rd_phy, rd_reg, exp_next);
            end
            if (exp_pre) begin
                exp_pre  <= 1'b0;
                exp_next <= 5'd31;
            end else begin
                exp_next <= exp_next - 5'd1;
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        wait (cycles > 150000);
        fails = fails + 1;
        $display("[TB] FAIL watchdog: got %0d cycles, expected under 150000", cycles);
        $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
        $finish;
    end

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        tests = tests + 1;
        if (got !== exp) begin
            fails = fails + 1;
            $display("[TB] FAIL %s: got %0h, expected %0h", req, got, exp);
        end
    endtask

    // Fill the responder: listed addresses qualify, odd others answer all ones,
    // even others lack auto-negotiation ability.
    task automatic load(input logic [31:0] good);
        for (int i = 0; i < 32; i++) begin
            if (good[i])       replies[i] = 16'h7809;
            else if (i[0])     replies[i] = 16'hFFFF;
            else               replies[i] = 16'h1800;
        end
    endtask

    task automatic go(input logic pe, input logic [4:0] pa);
        @(negedge clk);
        preset_en   = pe;
        preset_addr = pa;
        exp_pre     = pe;
        exp_next    = pe ? pa : 5'd31;
        reads       = 0;
        dones       = 0;
        seq_err     = 0;
        start       = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done();
        for (int k = 0; k < 3000 && !done; k++) @(negedge clk);
    endtask

    // Scenario table: {preset_en, preset_addr}, good map, {found, addr}, reads.
    localparam int NV = 8;
    localparam logic [5:0]  V_PRE [NV] = '{6'h00, 6'h00, 6'h27, 6'h29, 6'h00, 6'h24, 6'h00, 6'h00};
    localparam logic [31:0] V_GOOD[NV] = '{32'h0000_0020, 32'h0010_0008, 32'h4000_0080,
                                           32'h0000_1000, 32'h0000_0000, 32'h0000_0000,
                                           32'h0000_0001, 32'h8000_0000};
    localparam logic [5:0]  V_RES [NV] = '{6'h25, 6'h34, 6'h27, 6'h2C, 6'h00, 6'h00, 6'h20, 6'h3F};
    localparam int          V_RDS [NV] = '{27, 12, 1, 21, 32, 33, 32, 1};

    initial begin
        // R1: reset state.
        repeat (3) @(negedge clk);
        check("R1 busy", busy, 0);
        check("R1 outputs", {rd_req, done, found, not_found, phy_addr}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", {busy, rd_req, done, found, not_found, phy_addr}, 0);

        // R2: request rises on the cycle after start, at the preset address.
        load(32'h0);
        replies[17] = 16'h1808;
        go(1'b1, 5'd17);
        check("R2 req after start", {rd_req, rd_phy, rd_reg}, {1'b1, 5'd17, 5'd1});
        wait_done();
        check("R6 preset exact mask", {found, phy_addr}, {1'b1, 5'd17});
        @(negedge clk);

        // Table walk: R6, R7, R8, R9.
        for (int v = 0; v < NV; v++) begin
            load(V_GOOD[v]);
            go(V_PRE[v][5], V_PRE[v][4:0]);
            wait_done();
            check($sformatf("R8 v%0d result", v), {found, not_found, phy_addr},
                  {V_RES[v][5], ~V_RES[v][5], V_RES[v][4:0]});
            @(negedge clk);
            check($sformatf("R9 v%0d read count", v), reads, V_RDS[v]);
            check($sformatf("R7 v%0d order", v), seq_err, 0);
            check($sformatf("R10 v%0d done once", v), dones, 1);
        end

        // R4, R5: all ones rejected, missing bit rejected, extras ignored.
        load(32'h0);
        replies[31] = 16'hFFFF;
        replies[30] = 16'h0808;
        replies[29] = 16'h1008;
        replies[28] = 16'h1800;
        replies[27] = 16'hF8FF;
        go(1'b0, 5'd0);
        wait_done();
        check("R4 R5 qualification", {found, phy_addr}, {1'b1, 5'd27});
        @(negedge clk);
        check("R5 reads", reads, 5);

        // R11: a start while busy changes nothing; R10: results held, then cleared.
        load(32'h0000_0004);
        go(1'b0, 5'd0);
        repeat (10) @(negedge clk);
        start = 1'b1;
        preset_en = 1'b1;
        preset_addr = 5'd9;
        @(negedge clk);
        start = 1'b0;
        wait_done();
        check("R11 result", {found, phy_addr}, {1'b1, 5'd2});
        @(negedge clk);
        check("R11 reads", reads, 30);
        check("R11 order", seq_err, 0);
        check("R11 done once", dones, 1);
        repeat (5) @(negedge clk);
        check("R10 hold", {done, found, not_found, phy_addr}, {1'b0, 1'b1, 1'b0, 5'd2});
        load(32'h0);
        go(1'b0, 5'd0);
        check("R10 cleared by start", {found, not_found, phy_addr}, 0);
        wait_done();
        check("R9 none", {found, not_found, phy_addr}, {1'b0, 1'b1, 5'd0});
        repeat (5) @(negedge clk);
        check("R10 nf hold", {busy, not_found}, {1'b0, 1'b1});

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule